// File: doc/BRIEF.md
# Parity Small-Write Update Sequencer

This block carries out one partial-stripe write in a striped disk array that protects each stripe with a single XOR parity block. A command names a stripe, the logical data block within that stripe, and the new block contents. The sequencer works out which disk holds the parity for that stripe and which disk holds the addressed data block. It then fetches the old data block and the old parity block, one word per cycle, from a memory-mapped disk model. It writes the new data and the updated parity back to the same places.

Parity is not recomputed over the whole stripe. The sequencer XORs the change in the data block into the old parity. Each update therefore costs two block reads and two block writes, whatever the number of disks. While an update is in flight, new commands are refused, so the data and parity of a stripe cannot be left out of step by an interleaved request.

The disk model is addressed as `{disk, stripe, word}`. A read request returns its word on `mem_rdata` in the cycle that follows the request. A write request takes effect at the clock edge that ends its cycle.

Top module: `parity_rmw_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `busy`, `done` and `mem_req` are low.
- R2: The parity block of stripe s sits on disk (NDISK-1) - (s mod NDISK).
- R3: Logical data block b of a stripe sits on disk b when b is below that stripe's parity disk, and on disk b+1 otherwise. It is never placed on the parity disk.
- R4: An operation issues one memory access per cycle with no gaps, in this order: reads of data words 0 to WORDS-1, reads of parity words 0 to WORDS-1, writes of data words 0 to WORDS-1, then writes of parity words 0 to WORDS-1. Every access uses address `{disk, stripe, word}`.
- R5: Each operation makes exactly 2*WORDS reads followed by 2*WORDS writes, and no read follows a write within an operation.
- R6: Parity word i is written as old parity word i XOR old data word i XOR new data word i. As a result, every stripe keeps an all-zero XOR across its disks.
- R7: Data word i written to disk is bits [i*DW +: DW] of `cmd_data`, captured in the cycle the command is accepted.
- R8: When `cmd_valid` is high while `busy` is high, `cmd_reject` is high in that same cycle. The command has no effect: the operation in flight and the memory contents are unchanged by it.
- R9: `done` is high for exactly one cycle, the cycle that follows the last parity write. `busy` is high from the cycle after acceptance through the `done` cycle, and low in the cycle after it.
- R10: A command is accepted when `cmd_valid` is high and `busy` is low. The first data read appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_stripe | input | SW | Stripe number of the write |
| cmd_blk | input | DKW | Logical data block within the stripe (0 to NDISK-2) |
| cmd_data | input | WORDS*DW | New block contents, word 0 in the low bits |
| cmd_reject | output | 1 | Command refused because an update is in flight |
| busy | output | 1 | Update in flight |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write when high, a read when low |
| mem_addr | output | DKW+SW+WIW | Address `{disk, stripe, word}` |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the cycle after the read request |

## Verification
The assertions take two things for granted about the environment. First, the disk model returns read data exactly one cycle after each read request. Second, `cmd_blk` never exceeds NDISK-2; an out-of-range block would alias onto another disk. The stimulus keeps to both assumptions. The bench memory answers every read on the following edge, and each command uses a legal block index. The stimulus covers every parity rotation position, blocks on both sides of the parity disk, all-ones and all-zero data, and a repeated write to the same stripe. It also injects a command in the middle of a busy operation.

// File: rtl/prs_pkg.sv
`timescale 1ns/1ps
package prs_pkg;

    localparam int DEF_NDISK   = 4;
    localparam int DEF_WORDS   = 4;
    localparam int DEF_DW      = 16;
    localparam int DEF_NSTRIPE = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_DAT,
        PH_RD_PAR,
        PH_WR_DAT,
        PH_WR_PAR,
        PH_FIN
    } phase_e;

    // Disk that carries parity for a stripe; rotates downward stripe by stripe.
    function automatic logic [31:0] parity_slot(input logic [31:0] stripe,
                                                input logic [31:0] ndisk);
        return (ndisk - 32'd1) - (stripe % ndisk);
    endfunction

    // Logical data block index mapped around the parity disk.
    function automatic logic [31:0] data_slot(input logic [31:0] blk,
                                              input logic [31:0] pslot);
        return (blk < pslot) ? blk : blk + 32'd1;
    endfunction

endpackage

// File: rtl/prs_place.sv
module prs_place #(
    parameter int NDISK = 4,
    parameter int SW    = 3,
    parameter int DKW   = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [SW-1:0]  stripe,
    input  logic [DKW-1:0] blk,
    output logic [DKW-1:0] par_disk,
    output logic [DKW-1:0] dat_disk
);
    import prs_pkg::*;

    logic [31:0] p_slot;
    logic [31:0] d_slot;

    always_comb begin
        p_slot   = parity_slot(32'(stripe), 32'(NDISK));
        d_slot   = data_slot(32'(blk), p_slot);
        par_disk = DKW'(p_slot);
        dat_disk = DKW'(d_slot);
    end

    // R3: the data block never lands on the parity disk
    a_r3_data_off_parity: assert property (@(posedge clk) disable iff (rst)
        par_disk != dat_disk);

endmodule

// File: rtl/prs_fsm.sv
module prs_fsm #(
    parameter int WORDS = 4,
    parameter int WIW   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output prs_pkg::phase_e phase,
    output logic [WIW-1:0]  widx,
    output logic            cap_v,
    output logic            cap_par,
    output logic [WIW-1:0]  cap_idx,
    output logic            busy,
    output logic            done
);
    import prs_pkg::*;

    localparam logic [WIW-1:0] LAST = WIW'(WORDS - 1);

    phase_e nxt_blk;

    always_comb begin
        case (phase)
            PH_RD_DAT: nxt_blk = PH_RD_PAR;
            PH_RD_PAR: nxt_blk = PH_WR_DAT;
            PH_WR_DAT: nxt_blk = PH_WR_PAR;
            PH_WR_PAR: nxt_blk = PH_FIN;
            default:   nxt_blk = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            widx    <= '0;
            cap_v   <= 1'b0;
            cap_par <= 1'b0;
            cap_idx <= '0;
        end else begin
            cap_v   <= (phase == PH_RD_DAT) || (phase == PH_RD_PAR);
            cap_par <= (phase == PH_RD_PAR);
            cap_idx <= widx;
            case (phase)
                PH_IDLE: begin
                    widx <= '0;
                    if (start) phase <= PH_RD_DAT;
                end
                PH_FIN: phase <= PH_IDLE;
                default: begin
                    if (widx == LAST) begin
                        widx  <= '0;
                        phase <= nxt_blk;
                    end else begin
                        widx <= widx + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_FIN);

    // R9: completion is a single-cycle pulse and the block goes idle after it
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

endmodule

// File: rtl/prs_xorbuf.sv
module prs_xorbuf #(
    parameter int WORDS = 4,
    parameter int DW    = 16,
    parameter int WIW   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [WORDS*DW-1:0] blk_in,
    input  logic                cap_v,
    input  logic                cap_par,
    input  logic [WIW-1:0]      cap_idx,
    input  logic [DW-1:0]       rdata,
    input  logic [WIW-1:0]      rd_idx,
    output logic [DW-1:0]       nd_word,
    output logic [DW-1:0]       np_word
);
    logic [WORDS-1:0][DW-1:0] nd_a;
    logic [WORDS-1:0][DW-1:0] np_a;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DW-1:0] new_r;
        logic [DW-1:0] dlt_r;
        logic [DW-1:0] par_r;
        logic          hit;

        assign hit = cap_v && (cap_idx == WIW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                new_r <= '0;
                dlt_r <= '0;
                par_r <= '0;
            end else begin
                if (load) new_r <= blk_in[g*DW +: DW];
                if (hit && !cap_par) dlt_r <= rdata ^ new_r;
                if (hit && cap_par)  par_r <= rdata ^ dlt_r;
            end
        end

        assign nd_a[g] = new_r;
        assign np_a[g] = par_r;
    end

    assign nd_word = nd_a[rd_idx];
    assign np_word = np_a[rd_idx];

endmodule

// File: rtl/parity_rmw_seq.sv
module parity_rmw_seq #(
    parameter int NDISK   = prs_pkg::DEF_NDISK,
    parameter int WORDS   = prs_pkg::DEF_WORDS,
    parameter int DW      = prs_pkg::DEF_DW,
    parameter int NSTRIPE = prs_pkg::DEF_NSTRIPE,
    localparam int DKW    = $clog2(NDISK),
    localparam int SW     = $clog2(NSTRIPE),
    localparam int WIW    = $clog2(WORDS),
    localparam int AW     = DKW + SW + WIW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [SW-1:0]       cmd_stripe,
    input  logic [DKW-1:0]      cmd_blk,
    input  logic [WORDS*DW-1:0] cmd_data,
    output logic                cmd_reject,
    output logic                busy,
    output logic                done,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata
);
    import prs_pkg::*;

    phase_e         phase;
    logic [WIW-1:0] widx;
    logic           cap_v;
    logic           cap_par;
    logic [WIW-1:0] cap_idx;
    logic           accept;
    logic [SW-1:0]  stripe_q;
    logic [DKW-1:0] blk_q;
    logic [DKW-1:0] par_disk;
    logic [DKW-1:0] dat_disk;
    logic [DKW-1:0] tgt_disk;
    logic [DW-1:0]  nd_word;
    logic [DW-1:0]  np_word;

    assign accept     = cmd_valid && !busy;
    assign cmd_reject = cmd_valid && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            stripe_q <= '0;
            blk_q    <= '0;
        end else if (accept) begin
            stripe_q <= cmd_stripe;
            blk_q    <= cmd_blk;
        end
    end

    prs_fsm #(.WORDS(WORDS), .WIW(WIW)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .phase   (phase),
        .widx    (widx),
        .cap_v   (cap_v),
        .cap_par (cap_par),
        .cap_idx (cap_idx),
        .busy    (busy),
        .done    (done)
    );

    prs_place #(.NDISK(NDISK), .SW(SW), .DKW(DKW)) u_place (
        .clk      (clk),
        .rst      (rst),
        .stripe   (stripe_q),
        .blk      (blk_q),
        .par_disk (par_disk),
        .dat_disk (dat_disk)
    );

    prs_xorbuf #(.WORDS(WORDS), .DW(DW), .WIW(WIW)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .blk_in  (cmd_data),
        .cap_v   (cap_v),
        .cap_par (cap_par),
        .cap_idx (cap_idx),
        .rdata   (mem_rdata),
        .rd_idx  (widx),
        .nd_word (nd_word),
        .np_word (np_word)
    );

    always_comb begin
        mem_req   = phase inside {PH_RD_DAT, PH_RD_PAR, PH_WR_DAT, PH_WR_PAR};
        mem_we    = phase inside {PH_WR_DAT, PH_WR_PAR};
        tgt_disk  = (phase == PH_RD_DAT || phase == PH_WR_DAT) ? dat_disk : par_disk;
        mem_addr  = {tgt_disk, stripe_q, widx};
        mem_wdata = (phase == PH_WR_DAT) ? nd_word : np_word;
    end

    // Checker counter: reads issued since the last accepted command
    logic [WIW+1:0] rd_seen;
    always_ff @(posedge clk) begin
        if (rst || accept)          rd_seen <= '0;
        else if (mem_req && !mem_we) rd_seen <= rd_seen + 1'b1;
    end

    // R10: the first access after acceptance is a read
    a_r10_first_read: assert property (@(posedge clk) disable iff (rst)
        accept |=> (mem_req && !mem_we));

    // R5: all reads finish before the first write, and none follow a write
    a_r5_reads_before_write: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> (rd_seen == (WIW+2)'(2*WORDS)));

    a_r5_no_read_after_write: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> !(mem_req && !mem_we));

    // R8: a refused command leaves the captured target untouched
    a_r8_reject_no_effect: assert property (@(posedge clk) disable iff (rst)
        cmd_reject |=> ($stable(stripe_q) && $stable(blk_q)));

    // R9: completion follows a write to the parity disk
    a_r9_done_after_parity: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(mem_req && mem_we && (mem_addr[AW-1 -: DKW] == par_disk)));

endmodule

// File: tb/sim_parity_rmw_seq.sv
`timescale 1ns/1ps
module sim_parity_rmw_seq;
    localparam int ND   = 4;
    localparam int NW   = 4;
    localparam int DW   = 16;
    localparam int NS   = 8;
    localparam int DKW  = $clog2(ND);
    localparam int SW   = $clog2(NS);
    localparam int WIW  = $clog2(NW);
    localparam int AW   = DKW + SW + WIW;
    localparam int MEMN = 1 << AW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                rst;
    logic                cmd_valid;
    logic [SW-1:0]       cmd_stripe;
    logic [DKW-1:0]      cmd_blk;
    logic [NW*DW-1:0]    cmd_data;
    logic                cmd_reject, busy, done, mem_req, mem_we;
    logic [AW-1:0]       mem_addr;
    logic [DW-1:0]       mem_wdata;
    logic [DW-1:0]       mem_rdata;

    parity_rmw_seq #(.NDISK(ND), .WORDS(NW), .DW(DW), .NSTRIPE(NS)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_stripe(cmd_stripe),
        .cmd_blk(cmd_blk), .cmd_data(cmd_data), .cmd_reject(cmd_reject),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Disk model: one-cycle read latency
    logic [DW-1:0] disk_mem [MEMN];
    logic [DW-1:0] ref_mem  [MEMN];

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) disk_mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= disk_mem[mem_addr];
        end
    end

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t expq[$];
    exp_t cur;
    int   errs = 0;
    int   checks = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [AW-1:0] mk_addr(input int d, input int s, input int w);
        return {DKW'(d), SW'(s), WIW'(w)};
    endfunction

    function automatic int pdisk(input int s);
        return (ND - 1) - (s % ND);
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && mem_req) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R5 unexpected access", 32'(mem_addr), 32'hffff_ffff);
            end else begin
                cur = expq.pop_front();
                chk(mem_we == cur.we && mem_addr == cur.addr, {cur.tag, " kind/addr"},
                    {15'd0, mem_we, 16'(mem_addr)}, {15'd0, cur.we, 16'(cur.addr)});
                if (cur.we)
                    chk(mem_wdata == cur.data, {cur.tag, " data"},
                        32'(mem_wdata), 32'(cur.data));
            end
        end
    end

    task automatic run_op(input int s, input int b, input logic [NW*DW-1:0] blk,
                          input bit poke);
        int pd, dd;
        exp_t e;
        pd = pdisk(s);
        dd = (b < pd) ? b : b + 1;
        for (int w = 0; w < NW; w++) begin
            e.we = 1'b0; e.addr = mk_addr(dd, s, w); e.data = '0; e.tag = "R3 R4 data read";
            expq.push_back(e);
        end
        for (int w = 0; w < NW; w++) begin
            e.we = 1'b0; e.addr = mk_addr(pd, s, w); e.data = '0; e.tag = "R2 R4 parity read";
            expq.push_back(e);
        end
        for (int w = 0; w < NW; w++) begin
            e.we = 1'b1; e.addr = mk_addr(dd, s, w); e.data = blk[w*DW +: DW];
            e.tag = "R7 data write";
            expq.push_back(e);
        end
        for (int w = 0; w < NW; w++) begin
            e.we = 1'b1; e.addr = mk_addr(pd, s, w);
            e.data = ref_mem[mk_addr(pd, s, w)] ^ ref_mem[mk_addr(dd, s, w)] ^ blk[w*DW +: DW];
            e.tag = "R6 parity write";
            expq.push_back(e);
            ref_mem[mk_addr(pd, s, w)] = e.data;
            ref_mem[mk_addr(dd, s, w)] = blk[w*DW +: DW];
        end

        @(negedge clk);
        chk(busy == 1'b0, "R10 idle before command", 32'(busy), 32'd0);
        cmd_valid  = 1'b1;
        cmd_stripe = SW'(s);
        cmd_blk    = DKW'(b);
        cmd_data   = blk;
        #1;
        chk(cmd_reject == 1'b0, "R8 no reject when idle", 32'(cmd_reject), 32'd0);
        for (int c = 1; c <= 4*NW + 1; c++) begin
            @(negedge clk);
            if (c == 1) begin
                cmd_valid = 1'b0;
                chk(mem_req && !mem_we, "R10 first read next cycle",
                    {30'd0, mem_req, mem_we}, 32'd2);
            end
            if (poke && c == 3) begin
                cmd_valid  = 1'b1;
                cmd_stripe = SW'(s + 3);
                cmd_blk    = DKW'((b + 1) % (ND - 1));
                cmd_data   = ~blk;
                #1;
                chk(cmd_reject == 1'b1, "R8 reject while busy", 32'(cmd_reject), 32'd1);
            end
            if (poke && c == 4) cmd_valid = 1'b0;
            chk(busy == 1'b1, "R9 busy during op", 32'(busy), 32'd1);
            chk(done == (c == 4*NW + 1), "R9 done timing", 32'(done), 32'(c == 4*NW + 1));
        end
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9 idle after done",
            {30'd0, done, busy}, 32'd0);
        chk(expq.size() == 0, "R5 access count", 32'(expq.size()), 32'd0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [DW-1:0] acc, v;
        int pd;
        // Consistent initial stripes
        for (int s = 0; s < NS; s++) begin
            pd = pdisk(s);
            for (int w = 0; w < NW; w++) begin
                acc = '0;
                for (int d = 0; d < ND; d++) begin
                    if (d != pd) begin
                        v = 16'(s * 977 + w * 131 + d * 4099 + 29) ^ 16'((s + 1) * (d + 3) << 5);
                        disk_mem[mk_addr(d, s, w)] = v;
                        ref_mem[mk_addr(d, s, w)]  = v;
                        acc ^= v;
                    end
                end
                disk_mem[mk_addr(pd, s, w)] = acc;
                ref_mem[mk_addr(pd, s, w)]  = acc;
            end
        end

        rst = 1'b1;
        cmd_valid = 1'b0;
        cmd_stripe = '0;
        cmd_blk = '0;
        cmd_data = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R1 reset state",
            {29'd0, busy, done, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R1 after reset",
            {29'd0, busy, done, mem_req}, 32'd0);

        run_op(0, 0, 64'h1234_5678_9abc_def0, 1'b0);
        run_op(1, 2, 64'h0f0f_f0f0_aaaa_5555, 1'b1);
        run_op(2, 1, 64'hdead_beef_cafe_f00d, 1'b0);
        run_op(2, 1, 64'h0000_0000_0000_0000, 1'b0);
        run_op(3, 0, 64'hffff_ffff_ffff_ffff, 1'b0);
        run_op(5, 1, 64'h8001_4002_2004_1008, 1'b1);
        run_op(6, 2, 64'h1111_2222_3333_4444, 1'b0);
        run_op(7, 2, 64'h7e7e_0101_fe01_55aa, 1'b0);

        // R8 and R7: memory matches the model; refused commands changed nothing
        for (int a = 0; a < MEMN; a++)
            chk(disk_mem[a] == ref_mem[a], "R8 R7 memory contents",
                32'(disk_mem[a]), 32'(ref_mem[a]));
        // R6: every stripe still XORs to zero across its disks
        for (int s = 0; s < NS; s++) begin
            for (int w = 0; w < NW; w++) begin
                acc = '0;
                for (int d = 0; d < ND; d++) acc ^= disk_mem[mk_addr(d, s, w)];
                chk(acc == '0, "R6 stripe parity", 32'(acc), 32'd0);
            end
        end
        finish_run();
    end

endmodule